// File: doc/BRIEF.md
# Dual-Lane Fractional/Integer Multiply-Accumulate Unit

This block holds two signed 16x16 multiply-accumulate lanes that work side by side. Each lane has its own 40-bit accumulator. A per-cycle mode bit picks how both lanes read their operands. In fractional mode the operands are 1.15 values. Each 2.30 product is moved left by one place to 1.31 before it reaches the accumulator. In integer mode the product is added with no scaling.

The same per-cycle controls drive both lanes: a valid strobe, a clear/load bit, the mode bit and a saturate enable. The clear/load bit starts a fresh sum by writing the current product into the accumulator. With saturation on, the 40-bit sum clamps; with it off, the sum wraps. Each lane also gives a 32-bit readout of its accumulator, clamped to the signed 32-bit range.

Top module: `dual_mac`

## Requirements
- R1: Both lanes update in the same cycle from their own operand slices (lane k uses bits [16k+15:16k] of each operand bus and drives bits [40k+39:40k] of `acc_o` and [32k+31:32k] of `rd_o`). Neither lane's result depends on the other lane's operands.
- R2: With `frac_i`=1, the product added is the signed integer product a*b multiplied by two (the 2.30 product realigned to 1.31), sign-extended to 40 bits.
- R3: With `frac_i`=1 and both operands 0x8000, the product added is 0x7FFFFFFF (positive).
- R4: With `frac_i`=0, the product added is the signed integer product a*b, unscaled, sign-extended to 40 bits.
- R5: With `valid_i`=1 and `clear_i`=1, the accumulator is replaced by the current product. The previous value and `sat_i` play no part.
- R6: With `valid_i`=0, both accumulators keep their values. `clear_i`, `frac_i`, `sat_i` and the operands have no effect.
- R7: With `sat_i`=1, an accumulate that goes past the signed 40-bit range gives 0x7F_FFFF_FFFF on positive overflow and 0x80_0000_0000 on negative overflow.
- R8: With `sat_i`=0, an accumulate wraps modulo 2^40.
- R9: `rd_o` equals the low 32 bits of the accumulator when the value fits in signed 32 bits. Otherwise it is 0x7FFFFFFF for positive values and 0x80000000 for negative values.
- R10: The accumulator changes at the first rising clock edge after `valid_i` is sampled high, and not before it. A new operation is accepted every cycle.
- R11: After reset both accumulators and both readouts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe for both lanes |
| clear_i | input | 1 | Load the product instead of adding it |
| frac_i | input | 1 | 1: fractional 1.15 operands, 0: signed integer |
| sat_i | input | 1 | 1: saturate at 40 bits, 0: wrap |
| op_a_i | input | 32 | First operands, one 16-bit slice per lane |
| op_b_i | input | 32 | Second operands, one 16-bit slice per lane |
| acc_o | output | 80 | Accumulators, one 40-bit slice per lane |
| rd_o | output | 64 | 32-bit saturated readouts, one slice per lane |

## Verification
Two functions can land in the same cycle, and the bench provokes both pairings. First, the fractional -1 x -1 product clamp can fire while the accumulator is being driven into 40-bit saturation. The bench repeats 0x8000 x 0x8000 in fractional mode for over 256 cycles, while the other lane runs a large negative product in the same cycles. Second, a clear/load can arrive while the accumulator sits at a saturated limit. The bench issues one directly on the clamped value. Every case is judged against a 64-bit arithmetic model in the bench, which computes the expected accumulator and readout for each cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef struct packed {
    logic valid;
    logic clear;
    logic sat;
  } mac_ctrl_t;
endpackage

// File: rtl/dmac_product.sv
module dmac_product #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int unsigned PW = 2 * OP_W;
  localparam logic [OP_W-1:0] MIN_OP = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PW-1:0]   MAX_PR = {1'b0, {(PW-1){1'b1}}};

  logic signed [OP_W-1:0] a_s, b_s;
  logic signed [PW-1:0]   raw;
  logic [PW-1:0]          aligned;
  logic                   corner;

  assign a_s    = a_i;
  assign b_s    = b_i;
  assign raw    = a_s * b_s;
  assign corner = frac_i && (a_i == MIN_OP) && (b_i == MIN_OP);

  // 2.30 -> 1.31; only -1 x -1 cannot be represented
  always_comb begin
    if (corner)      aligned = MAX_PR;
    else if (frac_i) aligned = raw <<< 1;
    else             aligned = raw;
  end

  assign prod_o = {{(ACC_W-PW){aligned[PW-1]}}, aligned};

  always_comb begin
    if (frac_i && a_i != '0 && b_i != '0)
      assert_frac_sign_R2: assert (aligned[PW-1] == (a_i[OP_W-1] ^ b_i[OP_W-1]))
        else $error("fractional product sign wrong");
  end
endmodule

// File: rtl/dmac_lane.sv
module dmac_lane #(
  parameter int unsigned ACC_W = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  dmac_pkg::mac_ctrl_t ctrl_i,
  input  logic [ACC_W-1:0]    prod_i,
  output logic [ACC_W-1:0]    acc_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             ovf;

  assign sum = {acc_q[ACC_W-1], acc_q} + {prod_i[ACC_W-1], prod_i};
  assign ovf = sum[ACC_W] ^ sum[ACC_W-1];

  always_comb begin
    if (ctrl_i.clear)          acc_d = prod_i;
    else if (ctrl_i.sat && ovf) acc_d = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else                       acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (ctrl_i.valid) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.valid && ctrl_i.clear |=> acc_q == $past(prod_i))
    else $error("load did not take product");

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.valid |=> $stable(acc_q))
    else $error("accumulator moved without valid");

  assert_sat_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.valid && !ctrl_i.clear && ctrl_i.sat && (acc_q[ACC_W-1] == prod_i[ACC_W-1])
    |=> acc_q[ACC_W-1] == $past(acc_q[ACC_W-1]))
    else $error("saturating add flipped sign");

  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.valid && !ctrl_i.clear && !ctrl_i.sat
    |=> acc_q == ACC_W'($past(acc_q) + $past(prod_i)))
    else $error("wrapping add wrong");
endmodule

// File: rtl/dmac_readout.sv
module dmac_readout #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] rd_o
);
  localparam logic [OUT_W-1:0] RD_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] RD_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [ACC_W-OUT_W:0] guard;
  logic                 fits;

  assign guard = acc_i[ACC_W-1:OUT_W-1];
  assign fits  = (&guard) | ~(|guard);
  assign rd_o  = fits ? acc_i[OUT_W-1:0] : (acc_i[ACC_W-1] ? RD_MIN : RD_MAX);

  always_comb begin
    if (!$isunknown(acc_i))
      assert_rd_sign_R9: assert (rd_o[OUT_W-1] == acc_i[ACC_W-1])
        else $error("readout sign differs from accumulator");
  end
endmodule

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int unsigned LANES = 2,
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   clear_i,
  input  logic                   frac_i,
  input  logic                   sat_i,
  input  logic [LANES*OP_W-1:0]  op_a_i,
  input  logic [LANES*OP_W-1:0]  op_b_i,
  output logic [LANES*ACC_W-1:0] acc_o,
  output logic [LANES*OUT_W-1:0] rd_o
);
  dmac_pkg::mac_ctrl_t ctrl;

  assign ctrl.valid = valid_i;
  assign ctrl.clear = clear_i;
  assign ctrl.sat   = sat_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] acc;

    dmac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
      .a_i    (op_a_i[k*OP_W +: OP_W]),
      .b_i    (op_b_i[k*OP_W +: OP_W]),
      .frac_i (frac_i),
      .prod_o (prod)
    );

    dmac_lane #(.ACC_W(ACC_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl),
      .prod_i (prod),
      .acc_o  (acc)
    );

    dmac_readout #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rd (
      .acc_i (acc),
      .rd_o  (rd_o[k*OUT_W +: OUT_W])
    );

    assign acc_o[k*ACC_W +: ACC_W] = acc;
  end
endmodule

// File: tb/tb_dual_mac.sv
module tb_dual_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, clear = 1'b0, frac = 1'b0, sat = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [79:0] acc;
  logic [63:0] rd;

  int checks = 0;
  int errors = 0;
  longint ref_acc [2];

  always #5 clk = ~clk;

  dual_mac dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clear_i(clear),
    .frac_i(frac), .sat_i(sat), .op_a_i(op_a), .op_b_i(op_b),
    .acc_o(acc), .rd_o(rd)
  );

  localparam longint ACC_MAX = 64'sd549755813887;
  localparam longint ACC_MIN = -64'sd549755813888;

  function automatic longint mprod(logic [15:0] a, logic [15:0] b, logic f);
    longint p = longint'($signed(a)) * longint'($signed(b));
    if (f) begin
      if (a == 16'h8000 && b == 16'h8000) p = 64'sd2147483647;
      else p = p * 2;
    end
    return p;
  endfunction

  function automatic longint wrap40(longint x);
    logic signed [39:0] t = x[39:0];
    return longint'(t);
  endfunction

  function automatic logic [31:0] mrd(longint x);
    if (x > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (x < -64'sd2147483648) return 32'h8000_0000;
    return x[31:0];
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < 2; k++) begin
      logic signed [39:0] t = acc[k*40 +: 40];
      longint got = longint'(t);
      checks++;
      if (got != ref_acc[k]) begin
        errors++;
        $display("FAIL %s lane%0d acc got %h exp %h", tag, k, t, ref_acc[k][39:0]);
      end
      checks++;
      if (rd[k*32 +: 32] != mrd(ref_acc[k])) begin
        errors++;
        $display("FAIL R9 %s lane%0d rd got %h exp %h", tag, k, rd[k*32 +: 32], mrd(ref_acc[k]));
      end
    end
  endtask

  task automatic step(input logic [15:0] a0, input logic [15:0] b0,
                      input logic [15:0] a1, input logic [15:0] b1,
                      input logic v, input logic c, input logic f, input logic s,
                      input string tag);
    @(negedge clk);
    op_a = {a1, a0}; op_b = {b1, b0};
    valid = v; clear = c; frac = f; sat = s;
    #1 check_all({"R10 pre-edge ", tag});
    if (v) begin
      longint p [2];
      p[0] = mprod(a0, b0, f);
      p[1] = mprod(a1, b1, f);
      for (int k = 0; k < 2; k++) begin
        if (c) ref_acc[k] = p[k];
        else if (s) begin
          longint sm = ref_acc[k] + p[k];
          ref_acc[k] = (sm > ACC_MAX) ? ACC_MAX : (sm < ACC_MIN) ? ACC_MIN : sm;
        end else ref_acc[k] = wrap40(ref_acc[k] + p[k]);
      end
    end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'h8001, 16'hFFFF, 16'h4000, 16'hC000};
    ref_acc[0] = 0; ref_acc[1] = 0;
    repeat (3) @(posedge clk);
    #1 check_all("R11 reset");
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: load sweep over corner operands, both modes
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          step(vals[i], vals[j], vals[j], vals[7-i], 1'b1, 1'b1, m[0], 1'b0,
               m[0] ? "R1 R2 R3 R5 frac load" : "R1 R4 R5 int load");

    // R10: back-to-back accumulation, mixed modes, every cycle
    for (int i = 0; i < 40; i++)
      step(16'(i*1237 + 91), 16'(i*733 - 5000), 16'(i*3001), 16'(17 - i*411),
           1'b1, 1'b0, i[0], 1'b1, "R10 R2 R4 accumulate");

    // R6: valid low with every other control active
    for (int i = 0; i < 4; i++)
      step(16'h8000, 16'h8000, 16'h7FFF, 16'h8001, 1'b0, 1'b1, i[0], i[1], "R6 hold");

    // R7 with R3: -1 x -1 clamp while driving lane0 to +sat, lane1 to -sat
    step(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1, "R5 R3 start");
    for (int i = 0; i < 300; i++)
      step(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b1, "R7 R3 R9 sat");
    // R5 with R7: clear while saturated
    step(16'h1000, 16'h2000, 16'hF000, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b1, "R5 clear at sat");

    // R8: same drive with wrapping
    step(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0, "R8 start");
    for (int i = 0; i < 300; i++)
      step(16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b0, "R8 R9 wrap");

    // R7 integer mode negative saturation with R9 readout
    step(16'h8000, 16'h7FFF, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1, "R4 R5 int start");
    for (int i = 0; i < 520; i++)
      step(16'h8000, 16'h7FFF, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 R9 int sat");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule